// File: doc/BRIEF.md
# Set-Associative Data Cache with Selectable Write Policy

This block sits between a processor load/store port and a slower next-level memory port. Each byte address is cut into a tag, a set index and a line offset. The set index picks one set. The tags of every way in that set are compared at the same time, and the word of the matching way is returned in the same cycle as the request. When no way matches, the block stalls the processor. It then brings the whole line in from memory, one word per handshake, and completes the access from the freshly filled line.

Two parameters fix the store behaviour. The first picks between keeping modified lines in the cache with a dirty mark (copy-back) and sending every store hit on to memory (store-through). The second decides whether a store miss first fetches its line (allocate) or goes straight to memory and leaves the cache alone (bypass). Victims are picked least-recently-used within the set, and an invalid way is always taken first. The default geometry is 32 KB, 2 ways, 16-byte lines and 32-bit addresses, which gives 1024 sets, a 10-bit index, a 4-bit offset and an 18-bit tag.

Top module: `cache_sa_top`

## Requirements
- R1: For the default geometry, address bits [3:2] select the word in the line, bits [13:4] select the set and bits [31:14] form the tag. Addresses 16 KB apart therefore fall into the same set with different tags.
- R2: A read whose set holds a valid way with an equal tag completes in the request cycle (`cpu_req_ready` high while `cpu_req_valid` is high), returns the stored word and issues no memory request. At most one way of a set matches.
- R3: On a read miss, the whole line is fetched as word-serial reads starting at word 0 in ascending order. `cpu_req_ready` stays low until the line is installed, and the access then completes with the requested word.
- R4: In copy-back mode, a store hit writes only the cache, marks the line dirty and makes no memory write.
- R5: In copy-back mode, a miss whose victim is valid and dirty first writes all words of the victim line to memory, then fetches the new line. A clean victim is dropped without any memory write.
- R6: In store-through mode, a store hit updates the cached word and writes the same word to memory. The store completes in the cycle memory accepts that write.
- R7: With allocate selected, a store miss fetches the line, installs it and then applies the store. A later read of that line hits without memory traffic.
- R8: With bypass selected, a store miss makes exactly one memory write and no read, and leaves the cache unchanged, so a later read of that address misses.
- R9: The victim is an invalid way if the set has one. Otherwise it is the way of the set that was accessed least recently.
- R10: Reset clears every valid and dirty bit. No memory traffic happens while idle, and the first access to any line after reset misses.
- R11: A memory request, once raised, keeps its address, direction and write data stable until `mem_req_ready` accepts it. Read data is taken only when `mem_rsp_valid` is high.
- R12: The processor holds its request stable while `cpu_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Processor access request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Byte address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_req_ready | output | 1 | Access completes in this cycle |
| cpu_rsp_rdata | output | DATA_W | Load data, valid with ready on a load |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned read word |

## Verification
The bound checker watches, on every cycle, that no more than one way hits, that load hits never touch memory, that memory requests hold steady until accepted, and that a fill response never coincides with completion. Depending on the parameters, it also checks that copy-back store hits stay local and that store-through or bypassed stores reach memory in the completing cycle. Only the bench scenarios can show that the LRU order picks the right victim, that a dirty line's data actually lands in memory before its replacement, that bypassed stores leave the cache untouched, and that every load agrees with a flat memory model across random conflicting traffic. Two copies run side by side for this: one with copy-back and allocate, one with store-through and bypass.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_EVICT,
      ST_FILL_REQ,
      ST_FILL_WAIT,
      ST_STORE
   } cache_state_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cache_way.sv
module cache_way #(
   parameter int unsigned SETS   = 1024,
   parameter int unsigned TAG_W  = 18,
   parameter int unsigned WORDS  = 4,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned SEL_W = $clog2(WORDS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [IDX_W-1:0]               set_i,
   input  logic                           line_we_i,
   input  logic [TAG_W-1:0]               line_tag_i,
   input  logic [WORDS-1:0][DATA_W-1:0]   line_data_i,
   input  logic                           word_we_i,
   input  logic [SEL_W-1:0]               word_sel_i,
   input  logic [DATA_W-1:0]              word_data_i,
   input  logic                           word_dirty_i,
   output logic                           valid_o,
   output logic                           dirty_o,
   output logic [TAG_W-1:0]               tag_o,
   output logic [WORDS-1:0][DATA_W-1:0]   line_o
);

   logic [SETS-1:0]                valid_q;
   logic [SETS-1:0]                dirty_q;
   logic [TAG_W-1:0]               tag_q  [SETS];
   logic [WORDS-1:0][DATA_W-1:0]   data_q [SETS];

   // state bits: cleared by reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (line_we_i) begin
         valid_q[set_i] <= 1'b1;
         dirty_q[set_i] <= 1'b0;
      end else if (word_we_i && word_dirty_i) begin
         dirty_q[set_i] <= 1'b1;
      end
   end

   // storage arrays: no reset, qualified by valid
   always_ff @(posedge clk) begin
      if (line_we_i) begin
         tag_q[set_i]  <= line_tag_i;
         data_q[set_i] <= line_data_i;
      end else if (word_we_i) begin
         data_q[set_i][word_sel_i] <= word_data_i;
      end
   end

   assign valid_o = valid_q[set_i];
   assign dirty_o = dirty_q[set_i];
   assign tag_o   = tag_q[set_i];
   assign line_o  = data_q[set_i];

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int unsigned WAYS = 2,
   parameter int unsigned SETS = 1024,
   localparam int unsigned IDX_W = $clog2(SETS),
   localparam int unsigned WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set_i,
   input  logic             touch_i,
   input  logic [WAY_W-1:0] touch_way_i,
   input  logic [WAYS-1:0]  valid_i,
   output logic [WAY_W-1:0] victim_o
);

   // per-way age: 0 = most recent, WAYS-1 = least recent
   logic [WAY_W-1:0] age [WAYS];
   logic [WAY_W-1:0] touched_age;

   assign touched_age = age[touch_way_i];

   for (genvar w = 0; w < WAYS; w++) begin : g_age
      logic [SETS-1:0][WAY_W-1:0] age_q;

      assign age[w] = age_q[set_i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            age_q <= {SETS{WAY_W'(w)}};
         end else if (touch_i) begin
            if (WAY_W'(w) == touch_way_i) begin
               age_q[set_i] <= '0;
            end else if (age_q[set_i] < touched_age) begin
               age_q[set_i] <= age_q[set_i] + 1'b1;
            end
         end
      end
   end

   always_comb begin
      logic found;
      found    = 1'b0;
      victim_o = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (!valid_i[i] && !found) begin
            victim_o = WAY_W'(i);
            found    = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < WAYS; i++) begin
            if (age[i] == WAY_W'(WAYS - 1)) victim_o = WAY_W'(i);
         end
      end
   end

endmodule

// File: rtl/cache_sa_top.sv
module cache_sa_top #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CACHE_BYTES = 32768,
   parameter int unsigned WAYS        = 2,
   parameter int unsigned LINE_BYTES  = 16,
   parameter bit          WRITE_BACK  = 1'b1,
   parameter bit          WRITE_ALLOC = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_we,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   input  logic [DATA_W-1:0] cpu_req_wdata,
   output logic              cpu_req_ready,
   output logic [DATA_W-1:0] cpu_rsp_rdata,
   output logic              mem_req_valid,
   output logic              mem_req_we,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   input  logic              mem_req_ready,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata
);

   import cache_pkg::*;

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int unsigned SETS       = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int unsigned BSEL_W     = $clog2(WORD_BYTES);
   localparam int unsigned WSEL_W     = $clog2(WORDS);
   localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W      = $clog2(SETS);
   localparam int unsigned TAG_W      = ADDR_W - IDX_W - OFF_W;
   localparam int unsigned WAY_W      = $clog2(WAYS);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || !is_pow2(WORD_BYTES)) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (WAYS < 2 || !is_pow2(WAYS)) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (WORDS < 2 || !is_pow2(WORDS)) begin : g_bad_line
      $error("a line must hold a power-of-two count of at least 2 words");
   end
   if (SETS < 2 || !is_pow2(SETS)) begin : g_bad_sets
      $error("geometry must yield a power-of-two set count");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("address too narrow for index and offset");
   end

   // address fields
   logic [TAG_W-1:0]  req_tag;
   logic [IDX_W-1:0]  req_idx;
   logic [WSEL_W-1:0] req_word;
   logic              unused_addr_bits;

   assign req_tag          = cpu_req_addr[ADDR_W-1 -: TAG_W];
   assign req_idx          = cpu_req_addr[OFF_W +: IDX_W];
   assign req_word         = cpu_req_addr[BSEL_W +: WSEL_W];
   assign unused_addr_bits = ^cpu_req_addr[BSEL_W-1:0];

   // way array
   logic [WAYS-1:0]                way_valid;
   logic [WAYS-1:0]                way_dirty;
   logic [TAG_W-1:0]               way_tag  [WAYS];
   logic [WORDS-1:0][DATA_W-1:0]   way_line [WAYS];
   logic [WAYS-1:0]                hit_vec;
   logic [WAYS-1:0]                line_we_vec;
   logic [WAYS-1:0]                word_we_vec;
   logic [WORDS-1:0][DATA_W-1:0]   fill_line;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      cache_way #(
         .SETS   (SETS),
         .TAG_W  (TAG_W),
         .WORDS  (WORDS),
         .DATA_W (DATA_W)
      ) u_way (
         .clk          (clk),
         .rst_n        (rst_n),
         .set_i        (req_idx),
         .line_we_i    (line_we_vec[w]),
         .line_tag_i   (req_tag),
         .line_data_i  (fill_line),
         .word_we_i    (word_we_vec[w]),
         .word_sel_i   (req_word),
         .word_data_i  (cpu_req_wdata),
         .word_dirty_i (WRITE_BACK),
         .valid_o      (way_valid[w]),
         .dirty_o      (way_dirty[w]),
         .tag_o        (way_tag[w]),
         .line_o       (way_line[w])
      );
      assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
   end

   logic                         hit;
   logic [WAY_W-1:0]             hit_way;
   logic [WORDS-1:0][DATA_W-1:0] hit_line;

   assign hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (hit_vec[i]) hit_way = WAY_W'(i);
      end
   end

   assign hit_line      = way_line[hit_way];
   assign cpu_rsp_rdata = hit_line[req_word];

   // replacement
   logic             lru_touch;
   logic [WAY_W-1:0] victim_way;

   cache_lru #(
      .WAYS (WAYS),
      .SETS (SETS)
   ) u_lru (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (req_idx),
      .touch_i     (lru_touch),
      .touch_way_i (hit_way),
      .valid_i     (way_valid),
      .victim_o    (victim_way)
   );

   // miss sequencer
   cache_state_t                 state_q, state_d;
   logic [WSEL_W-1:0]            cnt_q, cnt_d;
   logic [WAY_W-1:0]             vic_q, vic_d;
   logic [WORDS-1:0][DATA_W-1:0] buf_q, buf_d;
   logic [WORDS-1:0][DATA_W-1:0] vic_line;
   logic [TAG_W-1:0]             vic_tag;
   logic                         last_word;

   assign vic_line  = way_line[vic_q];
   assign vic_tag   = way_tag[vic_q];
   assign last_word = (cnt_q == WSEL_W'(WORDS - 1));

   always_comb begin
      fill_line          = buf_q;
      fill_line[cnt_q]   = mem_rsp_rdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         vic_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         vic_q   <= vic_d;
      end
   end

   always_ff @(posedge clk) begin
      buf_q <= buf_d;
   end

   always_comb begin
      state_d       = state_q;
      cnt_d         = cnt_q;
      vic_d         = vic_q;
      buf_d         = buf_q;
      cpu_req_ready = 1'b0;
      mem_req_valid = 1'b0;
      mem_req_we    = 1'b0;
      mem_req_addr  = '0;
      mem_req_wdata = '0;
      line_we_vec   = '0;
      word_we_vec   = '0;
      lru_touch     = 1'b0;

      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req_valid) begin
               if (hit) begin
                  if (!cpu_req_we) begin
                     cpu_req_ready = 1'b1;
                     lru_touch     = 1'b1;
                  end else if (WRITE_BACK) begin
                     cpu_req_ready = 1'b1;
                     word_we_vec   = hit_vec;
                     lru_touch     = 1'b1;
                  end else begin
                     state_d = ST_STORE;
                  end
               end else if (cpu_req_we && !WRITE_ALLOC) begin
                  state_d = ST_STORE;
               end else begin
                  vic_d = victim_way;
                  cnt_d = '0;
                  if (WRITE_BACK && way_valid[victim_way] && way_dirty[victim_way])
                     state_d = ST_EVICT;
                  else
                     state_d = ST_FILL_REQ;
               end
            end
         end

         ST_EVICT: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = {vic_tag, req_idx, cnt_q, {BSEL_W{1'b0}}};
            mem_req_wdata = vic_line[cnt_q];
            if (mem_req_ready) begin
               if (last_word) begin
                  cnt_d   = '0;
                  state_d = ST_FILL_REQ;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end

         ST_FILL_REQ: begin
            mem_req_valid = 1'b1;
            mem_req_addr  = {req_tag, req_idx, cnt_q, {BSEL_W{1'b0}}};
            if (mem_req_ready) state_d = ST_FILL_WAIT;
         end

         ST_FILL_WAIT: begin
            if (mem_rsp_valid) begin
               buf_d[cnt_q] = mem_rsp_rdata;
               if (last_word) begin
                  line_we_vec[vic_q] = 1'b1;
                  cnt_d              = '0;
                  state_d            = ST_IDLE;
               end else begin
                  cnt_d   = cnt_q + 1'b1;
                  state_d = ST_FILL_REQ;
               end
            end
         end

         ST_STORE: begin
            mem_req_valid = 1'b1;
            mem_req_we    = 1'b1;
            mem_req_addr  = {cpu_req_addr[ADDR_W-1:BSEL_W], {BSEL_W{1'b0}}};
            mem_req_wdata = cpu_req_wdata;
            if (mem_req_ready) begin
               cpu_req_ready = 1'b1;
               state_d       = ST_IDLE;
               if (hit) begin
                  word_we_vec = hit_vec;
                  lru_touch   = 1'b1;
               end
            end
         end

         default: state_d = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/cache_sa_chk.sv
module cache_sa_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned WAYS        = 2,
   parameter bit          WRITE_BACK  = 1'b1,
   parameter bit          WRITE_ALLOC = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_valid,
   input logic              cpu_req_we,
   input logic [ADDR_W-1:0] cpu_req_addr,
   input logic              cpu_req_ready,
   input logic              mem_req_valid,
   input logic              mem_req_we,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_wdata,
   input logic              mem_req_ready,
   input logic              mem_rsp_valid,
   input logic [WAYS-1:0]   hit_vec
);

   localparam int unsigned BSEL_W = $clog2(DATA_W / 8);

   logic done_load;
   logic done_store;
   logic unused_chk;

   assign done_load  = cpu_req_valid && cpu_req_ready && !cpu_req_we;
   assign done_store = cpu_req_valid && cpu_req_ready && cpu_req_we;
   assign unused_chk = ^{cpu_req_addr, mem_req_addr, mem_req_wdata};

   AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec)); // R2

   AST_LOAD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done_load |-> !mem_req_valid); // R2

   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
         && $stable(mem_req_we) && $stable(mem_req_wdata)); // R11

   AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> !cpu_req_ready); // R3

   if (WRITE_BACK && WRITE_ALLOC) begin : g_wb
      AST_WB_STORE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
         done_store |-> !mem_req_valid); // R4
   end

   if (!WRITE_BACK) begin : g_wt
      AST_WT_STORE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
         done_store |-> mem_req_valid && mem_req_ready && mem_req_we
            && (mem_req_addr[ADDR_W-1:BSEL_W] == cpu_req_addr[ADDR_W-1:BSEL_W])); // R6
   end

   if (!WRITE_ALLOC) begin : g_around
      AST_AROUND_STORE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
         done_store && (hit_vec == '0) |-> mem_req_valid && mem_req_we); // R8
   end

endmodule

bind cache_sa_top cache_sa_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .WAYS        (WAYS),
   .WRITE_BACK  (WRITE_BACK),
   .WRITE_ALLOC (WRITE_ALLOC)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_we    (cpu_req_we),
   .cpu_req_addr  (cpu_req_addr),
   .cpu_req_ready (cpu_req_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_we    (mem_req_we),
   .mem_req_addr  (mem_req_addr),
   .mem_req_wdata (mem_req_wdata),
   .mem_req_ready (mem_req_ready),
   .mem_rsp_valid (mem_rsp_valid),
   .hit_vec       (hit_vec)
);

// File: tb/cache_sa_top_tb_top.sv
`timescale 1ns/1ps

module cache_sa_harness #(
   parameter int unsigned CACHE_BYTES = 32768,
   parameter bit          WRITE_BACK  = 1'b1,
   parameter bit          WRITE_ALLOC = 1'b1,
   parameter logic [15:0] SEED        = 16'hACE1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_we,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   output logic        done,
   output logic [31:0] rdata_cap,
   output int          lat_cap,
   output int          rd_cnt,
   output int          wr_cnt,
   input  logic [31:0] peek_addr,
   output logic [31:0] peek_data
);

   logic        dut_valid, ready;
   logic [31:0] rdata;
   logic        m_valid, m_we, m_ready, r_valid;
   logic [31:0] m_addr, m_wdata, r_data;
   logic [15:0] lfsr;
   int          lat;
   logic [31:0] store [int unsigned];

   function automatic logic [31:0] init_word(input logic [31:0] a);
      return 32'hC0DE_0000 ^ ((a >> 2) * 32'h9E37_79B1);
   endfunction

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      if (store.exists(a >> 2)) return store[a >> 2];
      return init_word(a);
   endfunction

   assign dut_valid = req_valid && !done;

   cache_sa_top #(
      .CACHE_BYTES (CACHE_BYTES),
      .WRITE_BACK  (WRITE_BACK),
      .WRITE_ALLOC (WRITE_ALLOC)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (dut_valid),
      .cpu_req_we    (req_we),
      .cpu_req_addr  (req_addr),
      .cpu_req_wdata (req_wdata),
      .cpu_req_ready (ready),
      .cpu_rsp_rdata (rdata),
      .mem_req_valid (m_valid),
      .mem_req_we    (m_we),
      .mem_req_addr  (m_addr),
      .mem_req_wdata (m_wdata),
      .mem_req_ready (m_ready),
      .mem_rsp_valid (r_valid),
      .mem_rsp_rdata (r_data)
   );

   // processor-side capture
   always @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0; lat <= 0; lat_cap <= 0; rdata_cap <= '0;
      end else if (dut_valid) begin
         if (ready) begin
            done      <= 1'b1;
            rdata_cap <= rdata;
            lat_cap   <= lat;
            lat       <= 0;
         end else begin
            lat <= lat + 1;
         end
      end else if (!req_valid) begin
         done <= 1'b0;
      end
   end

   // next-level memory with random acceptance
   always @(posedge clk) begin
      if (!rst_n) begin
         lfsr <= SEED; m_ready <= 1'b0; r_valid <= 1'b0; r_data <= '0;
         rd_cnt <= 0; wr_cnt <= 0;
      end else begin
         lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         m_ready <= lfsr[0] | lfsr[3];
         r_valid <= 1'b0;
         if (m_valid && m_ready) begin
            if (m_we) begin
               store[m_addr >> 2] = m_wdata;
               wr_cnt <= wr_cnt + 1;
            end else begin
               r_valid <= 1'b1;
               r_data  <= mem_word(m_addr);
               rd_cnt  <= rd_cnt + 1;
            end
         end
      end
   end

   always_comb peek_data = mem_word(peek_addr);

endmodule

module cache_sa_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] pk_addr = '0;

   logic        a_done, b_done;
   logic [31:0] a_rdata, b_rdata, a_peek, b_peek;
   int          a_lat, b_lat, a_rd, a_wr, b_rd, b_wr;

   int checks = 0;
   int fails  = 0;
   int a_rd0, a_wr0, b_rd0, b_wr0;
   logic [31:0] ref_mem [int unsigned];

   always #5 clk = ~clk;

   // copy-back + allocate, default geometry
   cache_sa_harness #(.CACHE_BYTES(32768), .WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1), .SEED(16'hACE1)) h_a (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .done(a_done), .rdata_cap(a_rdata), .lat_cap(a_lat),
      .rd_cnt(a_rd), .wr_cnt(a_wr), .peek_addr(pk_addr), .peek_data(a_peek));

   // store-through + bypass, 8 sets
   cache_sa_harness #(.CACHE_BYTES(256), .WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0), .SEED(16'h1D35)) h_b (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .done(b_done), .rdata_cap(b_rdata), .lat_cap(b_lat),
      .rd_cnt(b_rd), .wr_cnt(b_wr), .peek_addr(pk_addr), .peek_data(b_peek));

   function automatic logic [31:0] ref_rd(input logic [31:0] a);
      if (ref_mem.exists(a >> 2)) return ref_mem[a >> 2];
      return 32'hC0DE_0000 ^ ((a >> 2) * 32'h9E37_79B1);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic snap();
      a_rd0 = a_rd; a_wr0 = a_wr; b_rd0 = b_rd; b_wr0 = b_wr;
   endtask

   task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                         input string req);
      int guard;
      guard = 0;
      @(negedge clk);
      req_we = we; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
      do begin
         @(negedge clk);
         guard++;
      end while (!(a_done && b_done) && guard < 5000);
      req_valid = 1'b0;
      if (we) ref_mem[addr >> 2] = wd;
      else begin
         chk(req, a_rdata, ref_rd(addr));
         chk(req, b_rdata, ref_rd(addr));
      end
   endtask

   task automatic rand_phase();
      for (int k = 0; k < 400; k++) begin
         logic [31:0] a;
         a = 32'h100 + (($urandom % 5) * 32'h4000) + (($urandom % 3) * 16) + (($urandom % 4) * 4);
         if ($urandom % 3 == 0) access(1'b1, a, $urandom, "R4");
         else access(1'b0, a, '0, "R3");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (5) @(negedge clk);
      // R10: idle after reset, no memory traffic
      chk("R10", a_rd + a_wr, 0);
      chk("R10", b_rd + b_wr, 0);

      // R3 R10: first read misses, whole line fetched, stall lasts the fill
      snap();
      access(1'b0, 32'h100, '0, "R3");
      chk("R3", a_rd - a_rd0, 4);
      chk("R3", b_rd - b_rd0, 4);
      chk("R3", a_lat >= 8, 1);

      // R1 R2: another word of the same line hits in the request cycle
      snap();
      access(1'b0, 32'h104, '0, "R2");
      chk("R2", a_rd - a_rd0, 0);
      chk("R1", a_lat, 0);
      chk("R2", b_rd - b_rd0, 0);

      // R4 R6: store hit
      snap();
      access(1'b1, 32'h104, 32'h1111_2222, "R4");
      chk("R4", a_wr - a_wr0, 0);
      chk("R6", b_wr - b_wr0, 1);
      chk("R6", b_rd - b_rd0, 0);
      access(1'b0, 32'h104, '0, "R4");
      pk_addr = 32'h104; #1;
      chk("R4", a_peek, 32'hC0DE_0000 ^ ((32'h104 >> 2) * 32'h9E37_79B1));
      chk("R6", b_peek, 32'h1111_2222);

      // R7 R8: store miss
      snap();
      access(1'b1, 32'h2008, 32'h3333_4444, "R7");
      chk("R7", a_rd - a_rd0, 4);
      chk("R7", a_wr - a_wr0, 0);
      chk("R8", b_wr - b_wr0, 1);
      chk("R8", b_rd - b_rd0, 0);
      snap();
      access(1'b0, 32'h2008, '0, "R7");
      chk("R7", a_rd - a_rd0, 0);
      chk("R8", b_rd - b_rd0, 4);

      // R1 R9 R5: conflicts in set 0x10 of the copy-back cache (16 KB apart)
      snap();
      access(1'b0, 32'h4100, '0, "R9");
      chk("R9", a_rd - a_rd0, 4);
      chk("R1", a_wr - a_wr0, 0);
      snap();
      access(1'b0, 32'h100, '0, "R9");
      chk("R9", a_rd - a_rd0, 0);
      snap();
      access(1'b0, 32'h8100, '0, "R9");
      chk("R9", a_rd - a_rd0, 4);
      chk("R5", a_wr - a_wr0, 0);
      snap();
      access(1'b0, 32'h4100, '0, "R9");
      chk("R9", a_rd - a_rd0, 4);
      chk("R5", a_wr - a_wr0, 4);
      pk_addr = 32'h104; #1;
      chk("R5", a_peek, 32'h1111_2222);
      snap();
      access(1'b0, 32'h104, '0, "R5");
      chk("R5", a_rd - a_rd0, 4);
      chk("R5", a_wr - a_wr0, 0);

      // R12: mixed random traffic with conflicts, every load against the flat model
      rand_phase();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule